// File: doc/BRIEF.md
# Register File with Poison Tracking

This block is an integer register file in which every architectural register carries a poison flag beside its value. A load that misses far down the memory hierarchy can let the core keep executing speculatively rather than stall. In that mode the load's destination is written with the flag set. Any instruction that reads a poisoned source writes a poisoned result, and it may retire without executing. An instruction whose sources are all clean writes a clean result and clears the flag, as a move of a constant does. The register file reports, for the pair of sources being read, whether either one is poisoned. The issue logic uses that indication to pick the flag for the destination write.

A shadow array holds a checkpoint of every register value. A checkpoint strobe captures the whole live array in one cycle, on entry to speculative mode. A restore strobe copies the shadow back in one cycle on exit and clears every poison flag, so that normal execution resumes from the pre-speculation state. Register 0 always reads as zero and is never poisoned. Outside speculative mode, a write that asks for poison is reported as an error and stores a clean value.

Reads are combinational. A write becomes visible on the read ports in the cycle after its clock edge.

Top module: `poison_regfile`

## Requirements
- R1: After reset every register reads as value 0 with the poison flag clear on both read ports.
- R2: A write with `wr_en_i`=1 and `wr_inv_i`=0 to a nonzero register stores `wr_data_i` with the poison flag clear, and both read ports show it from the next cycle on.
- R3: With `runahead_i`=1, a write with `wr_inv_i`=1 stores the data with the poison flag set. A later clean write to the same register clears the flag.
- R4: `src_any_inv_o` is 1 exactly when `rd_a_inv_o` or `rd_b_inv_o` is 1.
- R5: With `runahead_i`=0, a write with `wr_en_i`=1 and `wr_inv_i`=1 raises `inv_err_o` in that same cycle. The data is stored with the poison flag clear. `inv_err_o` is 0 in every other case.
- R6: Register 0 reads as zero with the poison flag clear at all times, and writes to it have no effect.
- R7: A checkpoint pulse captures all register values into the shadow array in one cycle. A later restore pulse makes every register read its captured value from the next cycle on, regardless of the writes made in between.
- R8: A restore pulse clears the poison flag of every register.
- R9: When restore and a write fall in the same cycle, the restore wins and the write is dropped.
- R10: When a checkpoint and a write fall in the same cycle, the shadow captures the value the register held before that write. The write still updates the live register.
- R11: With `wr_en_i`=0, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| runahead_i | input | 1 | Core is in speculative (runahead) mode |
| rd_a_addr_i | input | 5 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A value |
| rd_a_inv_o | output | 1 | Read port A poison flag |
| rd_b_addr_i | input | 5 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B value |
| rd_b_inv_o | output | 1 | Read port B poison flag |
| src_any_inv_o | output | 1 | Either source read this cycle is poisoned |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register index |
| wr_data_i | input | 32 | Write value |
| wr_inv_i | input | 1 | Write requests the poison flag |
| inv_err_o | output | 1 | Poisoned write attempted outside speculative mode |
| ckpt_i | input | 1 | Checkpoint strobe |
| restore_i | input | 1 | Restore strobe |

## Verification
A corrupted poison flag or value shows on a read port in the first cycle that the affected register is addressed after the faulty edge. A flag left set across a restore shows up as a stuck `src_any_inv_o`. A stale or partial checkpoint stays hidden until the restore. It shows in the cycle after the restore pulse, when each register is read back against the value it held at the checkpoint edge. The bench therefore writes between checkpoint and restore and reads every touched register right after the restore.

// File: rtl/prf_pkg.sv
package prf_pkg;
  // how a qualified write lands in the live array
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_CLEAN  = 2'd1,
    WR_POISON = 2'd2,
    WR_REJECT = 2'd3  // poison requested outside runahead: stored clean
  } wr_kind_e;
endpackage

// File: rtl/prf_wr_gate.sv
module prf_wr_gate
  import prf_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_inv_i,
  input  logic          runahead_i,
  input  logic          restore_i,
  output wr_kind_e      kind_o,
  output logic          err_o
);
  assign err_o = wr_en_i & wr_inv_i & ~runahead_i;

  always_comb begin
    if (!wr_en_i || restore_i || (wr_addr_i == '0)) kind_o = WR_NONE;
    else if (wr_inv_i && runahead_i)                kind_o = WR_POISON;
    else if (wr_inv_i)                              kind_o = WR_REJECT;
    else                                            kind_o = WR_CLEAN;
  end
endmodule

// File: rtl/prf_bank.sv
module prf_bank
  import prf_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  wr_kind_e        kind_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            ckpt_i,
  input  logic            restore_i,
  output logic [XLEN-1:0] val_o [NREGS],
  output logic            inv_o [NREGS]
);
  assign val_o[0] = '0;
  assign inv_o[0] = 1'b0;

  for (genvar i = 1; i < NREGS; i++) begin : g_reg
    logic [XLEN-1:0] val_q, shd_q;
    logic            inv_q;
    logic            hit;

    assign hit = (kind_i != WR_NONE) && (wr_addr_i == AW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
        inv_q <= 1'b0;
      end else if (restore_i) begin
        val_q <= shd_q;
        inv_q <= 1'b0;
      end else if (hit) begin
        val_q <= wr_data_i;
        inv_q <= (kind_i == WR_POISON);
      end
    end

    // shadow takes the pre-edge live value; restore has precedence
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     shd_q <= '0;
      else if (ckpt_i && !restore_i)   shd_q <= val_q;
    end

    assign val_o[i] = val_q;
    assign inv_o[i] = inv_q;
  end
endmodule

// File: rtl/prf_rd_port.sv
module prf_rd_port #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [XLEN-1:0] val_i [NREGS],
  input  logic            inv_i [NREGS],
  output logic [XLEN-1:0] data_o,
  output logic            inv_o
);
  always_comb begin
    data_o = '0;
    inv_o  = 1'b0;
    for (int i = 0; i < NREGS; i++) begin
      if (addr_i == AW'(i)) begin
        data_o = val_i[i];
        inv_o  = inv_i[i];
      end
    end
  end
endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
  import prf_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            runahead_i,
  input  logic [AW-1:0]   rd_a_addr_i,
  output logic [XLEN-1:0] rd_a_data_o,
  output logic            rd_a_inv_o,
  input  logic [AW-1:0]   rd_b_addr_i,
  output logic [XLEN-1:0] rd_b_data_o,
  output logic            rd_b_inv_o,
  output logic            src_any_inv_o,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            wr_inv_i,
  output logic            inv_err_o,
  input  logic            ckpt_i,
  input  logic            restore_i
);
  localparam int unsigned NRD = 2;

  wr_kind_e        kind;
  logic [XLEN-1:0] vals [NREGS];
  logic            invs [NREGS];
  logic [AW-1:0]   rd_addr [NRD];
  logic [XLEN-1:0] rd_data [NRD];
  logic            rd_inv  [NRD];

  prf_wr_gate #(.AW(AW)) u_gate (
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_inv_i   (wr_inv_i),
    .runahead_i (runahead_i),
    .restore_i  (restore_i),
    .kind_o     (kind),
    .err_o      (inv_err_o)
  );

  prf_bank #(.NREGS(NREGS), .XLEN(XLEN)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kind_i    (kind),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ckpt_i    (ckpt_i),
    .restore_i (restore_i),
    .val_o     (vals),
    .inv_o     (invs)
  );

  assign rd_addr[0] = rd_a_addr_i;
  assign rd_addr[1] = rd_b_addr_i;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    prf_rd_port #(.NREGS(NREGS), .XLEN(XLEN)) u_rd (
      .addr_i (rd_addr[p]),
      .val_i  (vals),
      .inv_i  (invs),
      .data_o (rd_data[p]),
      .inv_o  (rd_inv[p])
    );
  end

  assign rd_a_data_o   = rd_data[0];
  assign rd_a_inv_o    = rd_inv[0];
  assign rd_b_data_o   = rd_data[1];
  assign rd_b_inv_o    = rd_inv[1];
  assign src_any_inv_o = rd_inv[0] | rd_inv[1];
endmodule

// File: rtl/prf_chk.sv
module prf_chk #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            runahead_i,
  input logic [AW-1:0]   rd_a_addr_i,
  input logic [XLEN-1:0] rd_a_data_o,
  input logic            rd_a_inv_o,
  input logic [AW-1:0]   rd_b_addr_i,
  input logic            rd_b_inv_o,
  input logic            src_any_inv_o,
  input logic            wr_en_i,
  input logic [AW-1:0]   wr_addr_i,
  input logic [XLEN-1:0] wr_data_i,
  input logic            wr_inv_i,
  input logic            inv_err_o,
  input logic            restore_i
);
  p_clean_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_inv_i && !restore_i && wr_addr_i != '0) |=>
      (rd_a_addr_i != $past(wr_addr_i)) ||
      (rd_a_data_o == $past(wr_data_i) && !rd_a_inv_o));

  p_any_inv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_inv_o || rd_b_inv_o) |-> src_any_inv_o);

  p_err_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_inv_i && !runahead_i) |-> inv_err_o);

  p_no_poison_outside_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_inv_i && !runahead_i && !restore_i && wr_addr_i != '0) |=>
      (rd_a_addr_i != $past(wr_addr_i)) || !rd_a_inv_o);

  p_zero_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == '0) |-> (rd_a_data_o == '0 && !rd_a_inv_o));

  p_restore_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (!rd_a_inv_o && !rd_b_inv_o && !src_any_inv_o));
endmodule

bind poison_regfile prf_chk #(.NREGS(NREGS), .XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .runahead_i    (runahead_i),
  .rd_a_addr_i   (rd_a_addr_i),
  .rd_a_data_o   (rd_a_data_o),
  .rd_a_inv_o    (rd_a_inv_o),
  .rd_b_addr_i   (rd_b_addr_i),
  .rd_b_inv_o    (rd_b_inv_o),
  .src_any_inv_o (src_any_inv_o),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .wr_inv_i      (wr_inv_i),
  .inv_err_o     (inv_err_o),
  .restore_i     (restore_i)
);

// File: tb/poison_regfile_test.sv
module poison_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        runahead_i = 1'b0;
  logic [4:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic        rd_a_inv_o, rd_b_inv_o, src_any_inv_o, inv_err_o;
  logic        wr_en_i = 1'b0, wr_inv_i = 1'b0, ckpt_i = 1'b0, restore_i = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  poison_regfile uut (.*);

  typedef struct packed {
    logic        ra;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        wi;
    logic [4:0]  aa;
    logic [4:0]  ab;
    logic [31:0] ea;
    logic        eai;
    logic [31:0] eb;
    logic        ebi;
    logic        eany;
    logic        eerr;
  } vec_t;

  localparam int NV = 10;
  // reads are checked before the edge that applies the same row's write
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 5'd0, 32'h0,    1'b0, 5'd1, 5'd2, 32'h0,    1'b0, 32'h0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 5'd1, 32'h11,   1'b0, 5'd1, 5'd2, 32'h0,    1'b0, 32'h0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 5'd2, 32'h22,   1'b0, 5'd1, 5'd2, 32'h11,   1'b0, 32'h0,  1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 5'd3, 32'hDEAD, 1'b1, 5'd1, 5'd2, 32'h11,   1'b0, 32'h22, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 5'd4, 32'h44,   1'b1, 5'd3, 5'd1, 32'hDEAD, 1'b1, 32'h11, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 5'd3, 32'h5,    1'b0, 5'd4, 5'd2, 32'h44,   1'b1, 32'h22, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 5'd0, 32'h0,    1'b0, 5'd3, 5'd4, 32'h5,    1'b0, 32'h44, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b1, 5'd5, 32'h55,   1'b1, 5'd0, 5'd0, 32'h0,    1'b0, 32'h0,  1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b1, 5'd0, 32'h99,   1'b0, 5'd5, 5'd0, 32'h55,   1'b0, 32'h0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 5'd0, 32'h0,    1'b0, 5'd0, 5'd5, 32'h0,    1'b0, 32'h55, 1'b0, 1'b0, 1'b0}
  };
  localparam string TAG [NV] = '{"R1", "R2", "R2", "R3", "R3", "R4", "R3",
                                 "R5", "R5", "R6"};

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic ra, input logic we, input logic [4:0] wa,
                       input logic [31:0] wd, input logic wi, input logic ck,
                       input logic rs, input logic [4:0] aa, input logic [4:0] ab);
    runahead_i = ra; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    wr_inv_i = wi; ckpt_i = ck; restore_i = rs;
    rd_a_addr_i = aa; rd_b_addr_i = ab;
    #1;
  endtask

  task automatic next();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    next();

    // R1: every register clean and zero after reset
    for (int r = 0; r < 32; r++) begin
      drive(1'b0, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b0, 5'(r), 5'(31 - r));
      check("R1", "reset value", rd_a_data_o | rd_b_data_o, 32'h0);
      check("R1", "reset inv", {31'h0, src_any_inv_o}, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].ra, VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].wi, 1'b0, 1'b0,
            VEC[i].aa, VEC[i].ab);
      check(TAG[i], "a data", rd_a_data_o, VEC[i].ea);
      check(TAG[i], "a inv", {31'h0, rd_a_inv_o}, {31'h0, VEC[i].eai});
      check(TAG[i], "b data", rd_b_data_o, VEC[i].eb);
      check(TAG[i], "b inv", {31'h0, rd_b_inv_o}, {31'h0, VEC[i].ebi});
      check("R4", "any inv", {31'h0, src_any_inv_o}, {31'h0, VEC[i].eany});
      check("R5", "err", {31'h0, inv_err_o}, {31'h0, VEC[i].eerr});
      next();
    end
    // state: r1=11 r2=22 r3=5 r4=44(inv) r5=55

    // R11: disabled write with live-looking inputs
    drive(1'b1, 1'b0, 5'd1, 32'hFF, 1'b1, 1'b0, 1'b0, 5'd1, 5'd1);
    check("R5", "err without enable", {31'h0, inv_err_o}, 32'h0);
    next();
    drive(1'b0, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b0, 5'd1, 5'd1);
    check("R11", "no write", rd_a_data_o, 32'h11);
    check("R11", "no poison", {31'h0, rd_a_inv_o}, 32'h0);
    next();

    // R10: checkpoint with a write in the same cycle
    drive(1'b1, 1'b1, 5'd1, 32'h77, 1'b0, 1'b1, 1'b0, 5'd1, 5'd2);
    next();
    drive(1'b1, 1'b1, 5'd2, 32'hBB, 1'b1, 1'b0, 1'b0, 5'd1, 5'd2);
    check("R10", "live updated", rd_a_data_o, 32'h77);
    next();
    drive(1'b1, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b0, 5'd1, 5'd2);
    check("R3", "poisoned in runahead", {31'h0, rd_b_inv_o}, 32'h1);
    check("R3", "poisoned data", rd_b_data_o, 32'hBB);
    next();

    // R9: restore together with a write
    drive(1'b1, 1'b1, 5'd3, 32'hCC, 1'b0, 1'b0, 1'b1, 5'd1, 5'd2);
    next();
    drive(1'b0, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b0, 5'd1, 5'd2);
    check("R10", "shadow pre-write r1", rd_a_data_o, 32'h11);
    check("R7", "restored r2", rd_b_data_o, 32'h22);
    check("R8", "r2 inv cleared", {31'h0, rd_b_inv_o}, 32'h0);
    next();
    drive(1'b0, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b0, 5'd3, 5'd4);
    check("R9", "write dropped", rd_a_data_o, 32'h5);
    check("R7", "restored r4", rd_b_data_o, 32'h44);
    check("R8", "r4 inv cleared", {31'h0, rd_b_inv_o}, 32'h0);
    check("R8", "any inv clear", {31'h0, src_any_inv_o}, 32'h0);
    next();

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule